// File: doc/BRIEF.md
# Page Readout Scan Chain

This block is a virtual test data register for reading a whole memory page out through a boundary-scan port. Seen from the serial side, it is a single long register of `8 * (PAGE_BYTES + 1)` bits. With the default 256-byte page that is 2056 bits. In hardware it holds only one 8-bit shifter, a 3-bit bit-position counter and a byte fetch counter. The block is active only when the instruction register holds the page-read code, 4'h7.

Each scan starts with a Capture-DR. Capture-DR clears the byte address and the bit position, but it does not load the shifter. The first eight Shift-DR clocks therefore shift out don't-care filler, which is whatever the shifter already held. On the eighth shift clock of every byte slot, an internal sequencer raises a read strobe and presents the current byte address to the page memory. The memory's asynchronous read port returns the byte in the same cycle. The sequencer loads that byte into the shifter in place of a shift and advances the address. Page byte 0 therefore appears on the serial output from bit 8 of the scan, least significant bit first, and the other bytes follow in ascending address order.

Serial input is discarded. Zeros are shifted in behind the data. Once every page byte has been fetched, no further reads are issued, and the output holds zero until the next capture.

Top module: `page_read_chain`

## Requirements
- R1: While reset is high at a clock edge, the shifter, the bit position and the byte address are cleared. After that edge `tdo` = 0 and `rd_addr` = 0.
- R2: The block acts only when `ir_code` equals SEL_CODE (default 4'h7). With any other code, `cap_dr` and `shf_dr` have no effect: `rd_en` stays 0, and `tdo` and `rd_addr` keep their values.
- R3: A selected Capture-DR sets `rd_addr` to 0 and the bit position to 0, and leaves the shifter untouched, so `tdo` is unchanged across the capture. When `cap_dr` and `shf_dr` are both high, the capture takes priority.
- R4: Count the selected shift cycles from the last capture as n = 0, 1, 2, and so on. `rd_en` is high in shift cycle n exactly when n mod 8 = 7 and n/8 < PAGE_BYTES. It is high in no other cycle.
- R5: In shift cycle n, `tdo` carries a stream defined as follows. For 8 ≤ n < 8*(PAGE_BYTES+1), the value is bit (n mod 8) of page byte (n/8 − 1), with bit 0 sent first. For n < 8 the value is filler.
- R6: For n ≥ 8*(PAGE_BYTES+1), `tdo` is 0 and no read is issued, until the next capture.
- R7: `tdi` never affects `tdo`, `rd_en` or `rd_addr`.
- R8: In a selected cycle that has neither capture nor shift (for example Pause-DR, Update-DR or Run-Test/Idle), all state holds. Shifting afterwards continues the same stream from where it stopped.
- R9: A capture in the middle of a scan restarts the stream: filler first, then byte 0.
- R10: Before shift cycle n, `rd_addr` equals min(n/8, PAGE_BYTES) modulo the page size. It steps by exactly one after each read and changes at no other time except on capture or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ir_code | input | IR_W (4) | Current instruction register contents |
| cap_dr | input | 1 | TAP controller is in Capture-DR |
| shf_dr | input | 1 | TAP controller is in Shift-DR |
| tdi | input | 1 | Serial data in; discarded |
| rd_data | input | 8 | Byte returned by the page memory's asynchronous read port |
| rd_en | output | 1 | Read strobe to the page memory |
| rd_addr | output | log2(PAGE_BYTES) | Byte address of the page memory read |
| tdo | output | 1 | Serial data out (shifter bit 0) |

## Verification
Two things can happen in the same cycle. On the last clock of each byte slot, the bit leaving on `tdo` is the final bit of the old byte, and the same edge replaces the whole shifter with a freshly fetched byte instead of shifting it. A fault in either the bit-7 output or the load priority therefore shows up only at byte boundaries. The bench provokes this by streaming full pages without a gap and by pausing exactly on a byte boundary before resuming. It compares every output bit, the strobe and the address against a stream computed from the page contents. Capture and shift asserted together are also driven once, to confirm that the capture wins.

// File: rtl/page_read_pkg.sv
`timescale 1ns/1ps
package page_read_pkg;

    localparam int BYTE_W = 8;
    localparam int POS_W  = $clog2(BYTE_W);

    // Qualified TAP activity for this data register
    typedef struct packed {
        logic capture;
        logic shift;
    } tap_act_t;

    // What the shifter does on the coming edge
    typedef enum logic [1:0] {
        SH_HOLD  = 2'd0,
        SH_SHIFT = 2'd1,
        SH_LOAD  = 2'd2
    } sh_op_t;

    function automatic logic last_bit_of_slot(input logic [POS_W-1:0] pos);
        return pos == POS_W'(BYTE_W - 1);
    endfunction

    function automatic logic [POS_W-1:0] next_pos(input logic [POS_W-1:0] pos);
        return last_bit_of_slot(pos) ? '0 : pos + POS_W'(1);
    endfunction

endpackage

// File: rtl/page_read_decode.sv
`timescale 1ns/1ps
module page_read_decode
    import page_read_pkg::*;
#(
    parameter int              IR_W     = 4,
    parameter logic [IR_W-1:0] SEL_CODE = 4'h7
) (
    input  logic [IR_W-1:0] ir_code,
    input  logic            cap_dr,
    input  logic            shf_dr,
    output tap_act_t        act
);
    logic selected;

    always_comb begin
        selected    = (ir_code == SEL_CODE);
        act.capture = selected & cap_dr;
        act.shift   = selected & shf_dr & ~cap_dr;
    end

endmodule

// File: rtl/page_read_seq.sv
`timescale 1ns/1ps
module page_read_seq
    import page_read_pkg::*;
#(
    parameter int PAGE_BYTES = 256,
    localparam int ADDR_W    = $clog2(PAGE_BYTES),
    localparam int CNT_W     = $clog2(PAGE_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  tap_act_t          act,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output sh_op_t            op
);
    logic [POS_W-1:0] bit_pos;
    logic [CNT_W-1:0] fetched;
    logic             page_done;

    always_comb begin
        page_done = (fetched == CNT_W'(PAGE_BYTES));
        rd_en     = act.shift & last_bit_of_slot(bit_pos) & ~page_done;
        rd_addr   = fetched[ADDR_W-1:0];
        if (rd_en)
            op = SH_LOAD;
        else if (act.shift)
            op = SH_SHIFT;
        else
            op = SH_HOLD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_pos <= '0;
            fetched <= '0;
        end else if (act.capture) begin
            bit_pos <= '0;
            fetched <= '0;
        end else if (act.shift) begin
            bit_pos <= next_pos(bit_pos);
            if (rd_en)
                fetched <= fetched + CNT_W'(1);
        end
    end

endmodule

// File: rtl/page_read_shifter.sv
`timescale 1ns/1ps
module page_read_shifter
    import page_read_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  sh_op_t            op,
    input  logic [BYTE_W-1:0] load_byte,
    output logic              tdo
);
    logic [BYTE_W-1:0] sreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg <= '0;
        end else begin
            unique case (op)
                SH_LOAD:  sreg <= load_byte;
                SH_SHIFT: sreg <= {1'b0, sreg[BYTE_W-1:1]};
                default:  sreg <= sreg;
            endcase
        end
    end

    assign tdo = sreg[0];

endmodule

// File: rtl/page_read_chain.sv
`timescale 1ns/1ps
module page_read_chain
    import page_read_pkg::*;
#(
    parameter int              PAGE_BYTES = 256,
    parameter int              IR_W       = 4,
    parameter logic [IR_W-1:0] SEL_CODE   = 4'h7,
    localparam int             ADDR_W     = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IR_W-1:0]   ir_code,
    input  logic              cap_dr,
    input  logic              shf_dr,
    input  logic              tdi,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              tdo
);
    tap_act_t act;
    sh_op_t   op;
    logic     unused_tdi;

    // Serial input is discarded; zeros enter behind the data
    assign unused_tdi = tdi;

    page_read_decode #(
        .IR_W     (IR_W),
        .SEL_CODE (SEL_CODE)
    ) u_decode (
        .ir_code (ir_code),
        .cap_dr  (cap_dr),
        .shf_dr  (shf_dr),
        .act     (act)
    );

    page_read_seq #(
        .PAGE_BYTES (PAGE_BYTES)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .act     (act),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .op      (op)
    );

    page_read_shifter u_shifter (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .load_byte (rd_data),
        .tdo       (tdo)
    );

endmodule

// File: rtl/page_read_chain_chk.sv
`timescale 1ns/1ps
module page_read_chain_chk #(
    parameter int              PAGE_BYTES = 256,
    parameter int              IR_W       = 4,
    parameter logic [IR_W-1:0] SEL_CODE   = 4'h7,
    localparam int             ADDR_W     = $clog2(PAGE_BYTES)
) (
    input logic              clk,
    input logic              rst,
    input logic [IR_W-1:0]   ir_code,
    input logic              cap_dr,
    input logic              shf_dr,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              tdo
);
    logic rst_q;

    always_ff @(posedge clk) rst_q <= rst;

    // R1: state is cleared after a reset edge
    always @(negedge clk) begin
        if (rst_q === 1'b1)
            assert_reset_clear_R1: assert (rd_addr == '0 && tdo == 1'b0);
    end

    // R2 / R4: a read only happens in a selected shift cycle
    assert_read_qualified_R4: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> (ir_code == SEL_CODE && shf_dr && !cap_dr));

    // R3: capture clears the address and leaves the shifter alone
    assert_capture_keeps_R3: assert property (@(posedge clk) disable iff (rst)
        (ir_code == SEL_CODE && cap_dr) |=> (rd_addr == '0 && tdo == $past(tdo)));

    // R8 / R2: with no selected activity nothing moves
    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !(ir_code == SEL_CODE && (cap_dr || shf_dr)) |=> ($stable(rd_addr) && $stable(tdo)));

    // R10: the address steps by one after each read
    assert_addr_step_R10: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !cap_dr) |=> (rd_addr == ADDR_W'($past(rd_addr) + 1'b1)));

endmodule

bind page_read_chain page_read_chain_chk #(
    .PAGE_BYTES (PAGE_BYTES),
    .IR_W       (IR_W),
    .SEL_CODE   (SEL_CODE)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .ir_code (ir_code),
    .cap_dr  (cap_dr),
    .shf_dr  (shf_dr),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .tdo     (tdo)
);

// File: tb/page_read_chain_bench.sv
`timescale 1ns/1ps
module page_read_chain_bench;
    localparam int PAGE_BYTES = 256;
    localparam int ADDR_W     = $clog2(PAGE_BYTES);
    localparam int CHAIN_LEN  = 8 * (PAGE_BYTES + 1);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [3:0]        ir_code = 4'h7;
    logic              cap_dr = 1'b0;
    logic              shf_dr = 1'b0;
    logic              tdi = 1'b0;
    logic [7:0]        rd_data;
    logic              rd_en;
    logic [ADDR_W-1:0] rd_addr;
    logic              tdo;

    int nvec = 0;
    int nerr = 0;
    int k    = 0;   // shift index since last capture

    always #2.5 clk = ~clk;

    function automatic logic [7:0] mem_byte(input int a);
        return 8'((a * 29 + 91) ^ (a >> 3));
    endfunction

    assign rd_data = mem_byte(int'(rd_addr));

    page_read_chain #(.PAGE_BYTES(PAGE_BYTES)) u_page_read_chain (
        .clk(clk), .rst(rst), .ir_code(ir_code), .cap_dr(cap_dr), .shf_dr(shf_dr),
        .tdi(tdi), .rd_data(rd_data), .rd_en(rd_en), .rd_addr(rd_addr), .tdo(tdo)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h (k=%0d)", req, act, exp, k);
        end
    endtask

    function automatic logic exp_rd(input int n);
        return (n % 8 == 7) && (n / 8 < PAGE_BYTES);
    endfunction

    function automatic logic [ADDR_W-1:0] exp_addr(input int n);
        int r = n / 8;
        if (r > PAGE_BYTES) r = PAGE_BYTES;
        return ADDR_W'(r);
    endfunction

    function automatic logic exp_bit(input int n);
        if (n >= CHAIN_LEN) return 1'b0;
        return mem_byte(n / 8 - 1)[n % 8];
    endfunction

    // One selected shift cycle, checked before its edge (R4 R5 R6 R10)
    task automatic shift_one(input logic din);
        @(negedge clk);
        cap_dr = 1'b0; shf_dr = 1'b1; tdi = din;
        #1;
        if (k >= 8) check("R5/R6 tdo", 32'(tdo), 32'(exp_bit(k)));
        check("R4 rd_en", 32'(rd_en), 32'(exp_rd(k)));
        check("R10 rd_addr", 32'(rd_addr), 32'(exp_addr(k)));
        k++;
    endtask

    task automatic capture(input logic with_shift);
        @(negedge clk);
        cap_dr = 1'b1; shf_dr = with_shift;
        @(negedge clk);
        cap_dr = 1'b0; shf_dr = 1'b0;
        k = 0;
    endtask

    task automatic t_reset;
        @(negedge clk); #1;
        check("R1 tdo", 32'(tdo), 0);
        check("R1 rd_addr", 32'(rd_addr), 0);
        check("R1 rd_en", 32'(rd_en), 0);
    endtask

    // Full page plus tail; tdi mode 0 = zeros, 1 = toggling (R7)
    task automatic t_full_scan(input bit tdi_toggle);
        capture(1'b0);
        for (int i = 0; i < CHAIN_LEN + 16; i++)
            shift_one(tdi_toggle ? logic'(i % 2) : 1'b0);
        @(negedge clk); shf_dr = 1'b0;
    endtask

    // Pauses mid-byte and on a byte boundary (R8)
    task automatic t_pause;
        logic       t0;
        logic [7:0] a0;
        capture(1'b0);
        for (int i = 0; i < 13; i++) shift_one(1'b0);
        for (int p = 0; p < 2; p++) begin
            @(negedge clk); shf_dr = 1'b0; #1;
            t0 = tdo; a0 = 8'(rd_addr);
            for (int i = 0; i < 5; i++) begin
                @(negedge clk); #1;
                check("R8 tdo hold", 32'(tdo), 32'(t0));
                check("R8 addr hold", 32'(rd_addr), 32'(a0));
                check("R8 no read", 32'(rd_en), 0);
            end
            while (k != 24) shift_one(1'b1);
        end
        for (int i = 0; i < 24; i++) shift_one(1'b0);
        @(negedge clk); shf_dr = 1'b0;
    endtask

    // Foreign instruction code freezes everything (R2)
    task automatic t_foreign;
        logic t0;
        capture(1'b0);
        for (int i = 0; i < 20; i++) shift_one(1'b0);
        @(negedge clk); shf_dr = 1'b0; ir_code = 4'h4; #1;
        t0 = tdo;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            cap_dr = (i == 2); shf_dr = 1'b1; #1;
            check("R2 no read", 32'(rd_en), 0);
            @(posedge clk); #1;
            check("R2 tdo frozen", 32'(tdo), 32'(t0));
            check("R2 addr frozen", 32'(rd_addr), 2);
        end
        @(negedge clk); cap_dr = 1'b0; shf_dr = 1'b0; ir_code = 4'h7;
        for (int i = 0; i < 40; i++) shift_one(1'b0);
        @(negedge clk); shf_dr = 1'b0;
    endtask

    // Capture mid-scan keeps shifter, restarts stream (R3 R9)
    task automatic t_recapture;
        logic t0;
        capture(1'b0);
        for (int i = 0; i < 35; i++) shift_one(1'b0);
        @(negedge clk); shf_dr = 1'b0; #1;
        t0 = tdo;
        capture(1'b1);   // capture with shift high: capture wins
        #1;
        check("R3 tdo unchanged", 32'(tdo), 32'(t0));
        check("R3 addr cleared", 32'(rd_addr), 0);
        for (int i = 0; i < 32; i++) shift_one(1'b1);   // R9 byte 0 onward
        @(negedge clk); shf_dr = 1'b0;
    endtask

    initial begin
        #(5.0 * 150000);
        nerr++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_full_scan(1'b0);
        t_full_scan(1'b1);
        t_pause();
        t_foreign();
        t_recapture();
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

endmodule